// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked request port and an external asynchronous static RAM of 32768 words by 8 bits. Each request is a single word read or write. The block accepts it through a valid/ready handshake and then steps the RAM's chip select, write enable and output enable through a fixed series of phases. Each phase lasts a whole number of clock cycles, and that count is set by a parameter. The phase lengths are chosen so that the RAM's minimum pulse widths, setup and hold intervals, access time and bus release time are all met. The 15-bit address is held constant for the whole access. On a read, the RAM data is captured on the last cycle of the access window and returned with a one-cycle valid pulse.

A write runs through three phases: setup, strobe and recovery. A read runs through an access window followed by a turnaround. During the turnaround every strobe is high and the data driver is off, so the RAM has time to release the shared bus before the controller drives it again. The bidirectional data bus is split into an output value, an output enable and an input value, which the chip pad logic combines. The default counts assume a 100 MHz clock and the fast RAM speed grade, with each nanosecond limit rounded up to whole cycles.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is high, and after it is released with no request, chip select, write enable and output enable are all high, the data driver is off, `rd_valid` is low and `req_ready` is high.
- R2: `req_ready` is high only when the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_write`=1 selects a write and 0 selects a read. `req_ready` then stays low for exactly T_WSU+T_WP+T_WR cycles after a write is accepted, or T_RD+T_TURN cycles after a read is accepted.
- R3: Whenever chip select is low on two consecutive cycles, `mem_addr` is the same on both cycles, and it equals the address that was accepted.
- R4: In a write, chip select goes low first, with write enable high, for T_WSU cycles. Write enable is then low for exactly T_WP cycles, with chip select low. Chip select stays low for T_WR more cycles after write enable rises. Write enable is never low while chip select is high.
- R5: Output enable is high throughout every write. The data driver is on only while output enable is high. The driver is on when the write ends, and the driven word does not change while the driver stays on.
- R6: In a read, chip select and output enable are low and write enable is high for exactly T_RD cycles. `mem_dq_in` is captured at the clock edge that ends this window. `rd_valid` is then high for exactly one cycle, the (T_RD+1)-th cycle after acceptance, and `rd_data` carries the captured word during that cycle.
- R7: After output enable rises at the end of a read, all strobes stay high and the driver stays off for at least T_TURN cycles before chip select falls again.
- R8: A word written to any address is returned by a later read of that address, for every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Word to write |
| rd_valid | output | 1 | One-cycle pulse marking returned read data |
| rd_data | output | DATA_W | Returned read word |
| mem_addr | output | ADDR_W | RAM address bus |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | DATA_W | Value the controller drives onto the data bus |
| mem_dq_oe | output | 1 | Controller data driver enable |
| mem_dq_in | input | DATA_W | Value present on the data bus |

## Verification
The bench uses a narrowed address width and runs three kinds of traffic against a behavioural RAM. Each word's expected data is computed arithmetically from its address.

The first pattern is an ascending sweep of writes followed by a descending sweep of reads. It shows whether every address stores and returns its own word, and whether the pulse, setup and recovery lengths are exact on every write.

The second pattern alternates, per address, a write, a read of that address, a read of the previous address and a rewrite. This covers write-to-read and read-to-write back-to-back turns. These are the only cases where the turnaround gap and the absence of bus contention can fail.

The RAM model returns filler data until T_RD cycles of read strobes have elapsed, so a capture made one cycle early shows up as a data mismatch.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_WSET   = 3'd1,
        PH_WPULSE = 3'd2,
        PH_WREC   = 3'd3,
        PH_RACC   = 3'd4,
        PH_RTURN  = 3'd5
    } phase_t;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic drive;
    } pins_t;

    localparam pins_t PINS_REST = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

    // Pin levels held during each phase.
    function automatic pins_t pins_for(input phase_t ph);
        pins_t p;
        p = PINS_REST;
        case (ph)
            PH_WSET: begin
                p.cs_n  = 1'b0;
                p.drive = 1'b1;
            end
            PH_WPULSE: begin
                p.cs_n  = 1'b0;
                p.we_n  = 1'b0;
                p.drive = 1'b1;
            end
            PH_WREC: begin
                p.cs_n  = 1'b0;
                p.drive = 1'b1;
            end
            PH_RACC: begin
                p.cs_n  = 1'b0;
                p.oe_n  = 1'b0;
            end
            default: p = PINS_REST;
        endcase
        return p;
    endfunction

    // Phase that follows the given one once its count runs out.
    function automatic phase_t phase_after(input phase_t ph);
        phase_t n;
        case (ph)
            PH_WSET:   n = PH_WPULSE;
            PH_WPULSE: n = PH_WREC;
            PH_RACC:   n = PH_RTURN;
            default:   n = PH_IDLE;
        endcase
        return n;
    endfunction

    // Length of each phase in clock cycles.
    function automatic int unsigned phase_span(
        input phase_t      ph,
        input int unsigned wsu,
        input int unsigned wp,
        input int unsigned wr,
        input int unsigned rd,
        input int unsigned turn
    );
        int unsigned s;
        case (ph)
            PH_WSET:   s = wsu;
            PH_WPULSE: s = wp;
            PH_WREC:   s = wr;
            PH_RACC:   s = rd;
            PH_RTURN:  s = turn;
            default:   s = 1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
    import sram_strobe_pkg::*;
#(
    parameter int unsigned T_WSU  = 1,
    parameter int unsigned T_WP   = 4,
    parameter int unsigned T_WR   = 1,
    parameter int unsigned T_RD   = 6,
    parameter int unsigned T_TURN = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  logic   req_write,
    output logic   idle,
    output logic   accept,
    output logic   capture,
    output phase_t phase_nxt
);
    localparam int unsigned M_A   = (T_WSU > T_WP) ? T_WSU : T_WP;
    localparam int unsigned M_B   = (T_WR > T_RD) ? T_WR : T_RD;
    localparam int unsigned M_C   = (M_A > M_B) ? M_A : M_B;
    localparam int unsigned T_MAX = (M_C > T_TURN) ? M_C : T_TURN;
    localparam int unsigned CNT_W = (T_MAX < 2) ? 1 : $clog2(T_MAX);

    phase_t             phase_q, phase_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic               last;

    function automatic logic [CNT_W-1:0] load_for(input phase_t ph);
        return CNT_W'(phase_span(ph, T_WSU, T_WP, T_WR, T_RD, T_TURN) - 1);
    endfunction

    assign last    = (cnt_q == '0);
    assign idle    = (phase_q == PH_IDLE);
    assign accept  = idle && req_valid;
    assign capture = (phase_q == PH_RACC) && last;

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (idle) begin
            if (req_valid) begin
                phase_d = req_write ? PH_WSET : PH_RACC;
                cnt_d   = load_for(phase_d);
            end
        end else if (last) begin
            phase_d = phase_after(phase_q);
            cnt_d   = load_for(phase_d);
        end else begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    assign phase_nxt = phase_d;

endmodule

// File: rtl/sram_pin_drv.sv
module sram_pin_drv
    import sram_strobe_pkg::*;
#(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  phase_t            phase_nxt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);
    pins_t             pins_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // Strobes come from flops loaded with the next phase's levels, so the pins
    // switch cleanly on the clock edge at which the phase itself changes.
    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q <= PINS_REST;
        end else begin
            pins_q <= pins_for(phase_nxt);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_cs_n   = pins_q.cs_n;
    assign mem_we_n   = pins_q.we_n;
    assign mem_oe_n   = pins_q.oe_n;
    assign mem_dq_out = wdata_q;
    assign mem_dq_oe  = pins_q.drive;

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_data <= mem_dq_in;
            end
        end
    end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_strobe_pkg::*;
#(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned T_WSU  = 1,
    parameter int unsigned T_WP   = 4,
    parameter int unsigned T_WR   = 1,
    parameter int unsigned T_RD   = 6,
    parameter int unsigned T_TURN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    logic   accept;
    logic   capture;
    phase_t phase_nxt;

    sram_phase_seq #(
        .T_WSU (T_WSU),
        .T_WP  (T_WP),
        .T_WR  (T_WR),
        .T_RD  (T_RD),
        .T_TURN(T_TURN)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .idle     (req_ready),
        .accept   (accept),
        .capture  (capture),
        .phase_nxt(phase_nxt)
    );

    sram_pin_drv #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_pins (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .phase_nxt (phase_nxt),
        .mem_addr  (mem_addr),
        .mem_cs_n  (mem_cs_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_dq_out(mem_dq_out),
        .mem_dq_oe (mem_dq_oe)
    );

    sram_rd_capture #(
        .DATA_W(DATA_W)
    ) u_cap (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .mem_dq_in(mem_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/sram_strobe_chk.sv
module sram_strobe_chk #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    assert_idle_pins_R1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

    assert_we_inside_cs_R4: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_cs_n);

    assert_oe_off_in_write_R5: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    assert_no_contention_R5: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    assert_wdata_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    assert_valid_after_read_R6: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(!mem_oe_n) && mem_oe_n));

    assert_turn_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(!mem_oe_n) && mem_oe_n) |-> (mem_cs_n && !mem_dq_oe));

endmodule

bind sram_strobe_ctrl sram_strobe_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_strobe_ctrl_test.sv
module sram_strobe_ctrl_test;
    localparam int AW     = 10;
    localparam int DW     = 8;
    localparam int N      = 1 << AW;
    localparam int T_WSU  = 1;
    localparam int T_WP   = 4;
    localparam int T_WR   = 1;
    localparam int T_RD   = 6;
    localparam int T_TURN = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sram_strobe_ctrl #(
        .ADDR_W(AW), .DATA_W(DW),
        .T_WSU(T_WSU), .T_WP(T_WP), .T_WR(T_WR), .T_RD(T_RD), .T_TURN(T_TURN)
    ) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] pat_a(input int a);
        return DW'((a * 29 + 7) ^ (a >> 2));
    endfunction

    function automatic logic [DW-1:0] pat_b(input int a);
        return ~pat_a(a) ^ 8'h3C;
    endfunction

    // Behavioural RAM: data only becomes valid after T_RD cycles of read strobes.
    logic [DW-1:0] ram [N];
    int  rd_age = 0;
    logic mdl_drive;
    assign mdl_drive = !mem_cs_n && !mem_oe_n && mem_we_n;

    always_comb begin
        if (mdl_drive && rd_age >= T_RD) mem_dq_in = ram[mem_addr];
        else                             mem_dq_in = 8'hA5;
    end

    // Pin timing monitor, sampled away from the active edge.
    logic p_cs = 1'b1, p_we = 1'b1, p_oe = 1'b1;
    logic [AW-1:0] p_addr = '0;
    int setup_run = 0, we_run = 0, rec_run = 0, oe_run = 0, high_run = 0;
    bit wrote = 0, after_read = 0;

    always @(negedge clk) begin
        if (rst) begin
            p_cs = 1'b1; p_we = 1'b1; p_oe = 1'b1;
            setup_run = 0; we_run = 0; rec_run = 0; oe_run = 0; high_run = 0;
            wrote = 0; after_read = 0; rd_age = 0;
        end else begin
            chk(!(mem_dq_oe && mdl_drive), "R5 bus contention", int'(mem_dq_oe), 0);
            if (!p_cs && !mem_cs_n)
                chk(mem_addr == p_addr, "R3 address hold", int'(mem_addr), int'(p_addr));
            if (!p_we && !p_cs && (mem_we_n || mem_cs_n)) begin
                chk(mem_dq_oe, "R5 driver on at write end", int'(mem_dq_oe), 1);
                ram[mem_addr] = mem_dq_out;
            end
            if (p_we && !mem_we_n) begin
                chk(setup_run == T_WSU, "R4 setup before strobe", setup_run, T_WSU);
                chk(mem_oe_n, "R5 oe high in write", int'(mem_oe_n), 1);
                wrote = 1;
            end
            if (!p_we && mem_we_n)
                chk(we_run == T_WP, "R4 strobe width", we_run, T_WP);
            if (!p_cs && mem_cs_n && wrote) begin
                chk(rec_run == T_WR, "R4 recovery", rec_run, T_WR);
                wrote = 0;
            end
            if (!p_oe && mem_oe_n) begin
                chk(oe_run == T_RD, "R6 read window", oe_run, T_RD);
                after_read = 1;
                high_run = 0;
            end
            if (p_cs && !mem_cs_n && after_read) begin
                chk(high_run >= T_TURN, "R7 turnaround", high_run, T_TURN);
                after_read = 0;
            end
            // run-length bookkeeping
            if (!mem_cs_n && mem_we_n && mem_oe_n && !wrote) setup_run++; else setup_run = 0;
            if (!mem_we_n) we_run++; else we_run = 0;
            if (!mem_cs_n && mem_we_n && wrote) rec_run++; else rec_run = 0;
            if (!mem_oe_n) oe_run++; else oe_run = 0;
            if (mem_cs_n) high_run++; else high_run = 0;
            if (mdl_drive) rd_age++; else rd_age = 0;
            p_cs = mem_cs_n; p_we = mem_we_n; p_oe = mem_oe_n; p_addr = mem_addr;
        end
    end

    // One transaction; called at a negedge with the block idle.
    task automatic xfer(input bit wr, input int a, input logic [DW-1:0] d,
                        output logic [DW-1:0] got);
        int busy = 0;
        int seen = 0;
        int at = 0;
        chk(req_ready, "R2 ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(a);
        req_wdata = d;
        got = '0;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) begin
            busy++;
            if (rd_valid) begin
                seen++;
                at = busy;
                got = rd_data;
            end
            @(negedge clk);
        end
        if (wr) begin
            chk(busy == T_WSU + T_WP + T_WR, "R2 write busy length", busy, T_WSU + T_WP + T_WR);
            chk(seen == 0, "R6 no valid on write", seen, 0);
        end else begin
            chk(busy == T_RD + T_TURN, "R2 read busy length", busy, T_RD + T_TURN);
            chk(seen == 1, "R6 single valid pulse", seen, 1);
            chk(at == T_RD + 1, "R6 valid cycle", at, T_RD + 1);
        end
    endtask

    initial begin
        logic [DW-1:0] got;
        for (int i = 0; i < N; i++) ram[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes high in reset", int'({mem_cs_n, mem_we_n, mem_oe_n}), 7);
        chk(!mem_dq_oe && !rd_valid, "R1 driver off in reset", int'({mem_dq_oe, rd_valid}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(req_ready, "R1 ready after reset", int'(req_ready), 1);
        chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 idle pins",
            int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}), 14);

        // ascending writes, then descending reads
        for (int a = 0; a < N; a++) xfer(1'b1, a, pat_a(a), got);
        for (int a = N - 1; a >= 0; a--) begin
            xfer(1'b0, a, 8'h00, got);
            chk(got == pat_a(a), "R8 sweep readback", int'(got), int'(pat_a(a)));
        end

        // interleaved turns: write, read same, read previous, rewrite
        for (int a = 1; a < N; a += 4) begin
            xfer(1'b1, a, pat_b(a), got);
            xfer(1'b0, a, 8'h00, got);
            chk(got == pat_b(a), "R8 write then read", int'(got), int'(pat_b(a)));
            xfer(1'b0, a - 1, 8'h00, got);
            chk(got == pat_a(a - 1), "R8 neighbour intact", int'(got), int'(pat_a(a - 1)));
            xfer(1'b1, a - 1, pat_b(a - 1), got);
        end
        for (int a = 0; a < N; a += 4) begin
            xfer(1'b0, a, 8'h00, got);
            chk(got == pat_b(a), "R8 read after rewrite", int'(got), int'(pat_b(a)));
        end

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule